// File: doc/BRIEF.md
# NAND Page Hamming ECC Engine

The engine builds a Hamming-style check code over one NAND flash page while the page streams through it, one word per accepted cycle. No separate pass over the data is needed. A start pulse opens a page and captures two settings: the bus width (8 or 16 bits) and a page size. Each word that carries a valid strobe is folded into a set of parity accumulators. The position of the word inside the page is its word address. When the page is written, the finished code is read from `ecc_calc_o` and stored beside the data.

When the page is read back, the stored code is presented on `ecc_stored_i` before the last word arrives. The engine XORs it with the freshly built code to form a syndrome and classifies the page in one of four ways: clean, one flipped data bit (correctable, with the word address and bit position of the bad bit), one flipped bit inside the stored code itself (correctable, no data location), or an uncorrectable multi-bit error. The report appears one cycle after the last word of the page. It holds until the next start pulse.

Top module: `nand_ecc_engine`

## Requirements
- R1: After a page, `ecc_calc_o` holds the code of the words accepted in that page. Bit ECC_W-1 is the XOR of all data bits. For each word address bit k, bit AW+k is the XOR of the data bits of all words whose address has bit k set, and bit k is the same for words where it is clear (AW = 12). For each bit-index bit j, bit 2*AW+CW+j is the XOR of all data bits whose in-word bit index has bit j set, and bit 2*AW+j is the same for bits where it is clear (CW = 4).
- R2: `rpt_valid_o` rises exactly one cycle after the last word of a page is accepted and never earlier. It stays high until a start pulse, which clears it on the next cycle.
- R3: A zero syndrome reports `err_o`=0 and `correctable_o`=0.
- R4: One flipped data bit reports `err_o`=1, `correctable_o`=1, `ecc_fault_o`=0 and `loc_valid_o`=1. `err_word_o` is the word address of the bad word and `err_bit_o` is the bit index of the bad bit.
- R5: Two flipped data bits anywhere in the page, including in the same word, report `err_o`=1 and `correctable_o`=0.
- R6: A syndrome with exactly one bit set reports `err_o`=1, `correctable_o`=1, `ecc_fault_o`=1 and `loc_valid_o`=0.
- R7: A page holds (512 << `page_sel_i`) >> `bus16_i` words, using the values captured at the start pulse. 8-bit mode is `bus16_i`=0; 16-bit mode is `bus16_i`=1.
- R8: In 8-bit mode, `data_i[15:8]` has no effect on the code or the report.
- R9: Cycles with `valid_i` low are ignored. Words after the end of the page are ignored until the next start, so the code and the report stay unchanged.
- R10: After reset, `rpt_valid_o`, `err_o`, `correctable_o`, `ecc_fault_o`, `loc_valid_o` and `ecc_calc_o` are all zero. All report flags read zero whenever `rpt_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Opens a new page; captures width and size, clears accumulators and report |
| bus16_i | input | 1 | 1 = 16-bit words, 0 = 8-bit words |
| page_sel_i | input | 2 | Page size: 512, 1024, 2048 or 4096 bytes |
| data_i | input | 16 | Data word |
| valid_i | input | 1 | Data word strobe |
| ecc_stored_i | input | 33 | Stored code, sampled with the last word |
| ecc_calc_o | output | 33 | Running or finished computed code |
| rpt_valid_o | output | 1 | Report valid |
| err_o | output | 1 | Nonzero syndrome |
| correctable_o | output | 1 | Single-bit error |
| ecc_fault_o | output | 1 | Error lies in the stored code |
| loc_valid_o | output | 1 | Data location outputs are meaningful |
| err_word_o | output | 12 | Word address of the bad bit |
| err_bit_o | output | 4 | Bit index of the bad bit |

## Verification
Pages are streamed in both widths and all four sizes, with gap cycles mixed in. In 8-bit mode the upper data byte carries junk. Clean pages are compared against single data-bit flips at the first word, the last word and inner words. Each flip checks that the row and column halves of the code point to the right address. Double flips, both in different words and in one word, separate uncorrectable pages from correctable ones. A flip of one stored code bit, the overall bit or a row bit, separates a fault in the code from a data fault.

// File: rtl/ecc_pkg.sv
package ecc_pkg;

  // Outcome of comparing stored and computed check codes.
  typedef enum logic [1:0] {
    SYN_CLEAN = 2'd0,
    SYN_DATA1 = 2'd1,
    SYN_CODE1 = 2'd2,
    SYN_MULTI = 2'd3
  } syn_kind_e;

  // Number of words in a page for a size selection and bus width.
  function automatic int unsigned words_in_page(input int unsigned base_bytes,
                                                input logic [1:0]  sel,
                                                input logic        wide);
    int unsigned bytes;
    bytes = base_bytes << sel;
    return wide ? (bytes >> 1) : bytes;
  endfunction

endpackage

// File: rtl/ecc_word_counter.sv
module ecc_word_counter #(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          valid_i,
  input  logic [AW:0]   page_words_i,
  output logic [AW-1:0] addr_o,
  output logic          take_o,
  output logic          last_o,
  output logic          busy_o
);

  logic [AW-1:0] cnt_q;
  logic          busy_q;
  logic [AW:0]   last_idx;

  assign last_idx = page_words_i - {{AW{1'b0}}, 1'b1};
  assign take_o   = valid_i & busy_q & ~start_i;
  assign last_o   = take_o & ({1'b0, cnt_q} == last_idx);
  assign addr_o   = cnt_q;
  assign busy_o   = busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (start_i) begin
      cnt_q  <= '0;
      busy_q <= 1'b1;
    end else if (take_o) begin
      if (last_o) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q  <= cnt_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/ecc_parity_accum.sv
module ecc_parity_accum #(
  parameter int AW = 12,
  parameter int CW = 4,
  parameter int DW = 16,
  localparam int ECC_W = 1 + 2 * CW + 2 * AW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             take_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    data_i,
  output logic [ECC_W-1:0] ecc_q_o,
  output logic [ECC_W-1:0] ecc_next_o
);

  // Column masks: bit b of mask j is bit j of the index b.
  logic [DW-1:0] col_mask [CW];

  for (genvar j = 0; j < CW; j++) begin : g_mask
    for (genvar b = 0; b < DW; b++) begin : g_bit
      assign col_mask[j][b] = ((b >> j) & 1) != 0;
    end
  end

  logic [ECC_W-1:0] acc_q;
  logic [ECC_W-1:0] folded;
  logic             word_par;

  assign word_par = ^data_i;

  always_comb begin
    folded = acc_q;
    for (int k = 0; k < AW; k++) begin
      folded[AW + k] = acc_q[AW + k] ^ (word_par & addr_i[k]);
      folded[k]      = acc_q[k]      ^ (word_par & ~addr_i[k]);
    end
    for (int j = 0; j < CW; j++) begin
      folded[2*AW + CW + j] = acc_q[2*AW + CW + j] ^ (^(data_i & col_mask[j]));
      folded[2*AW + j]      = acc_q[2*AW + j]      ^ (^(data_i & ~col_mask[j]));
    end
    folded[ECC_W-1] = acc_q[ECC_W-1] ^ word_par;
  end

  assign ecc_next_o = take_i ? folded : acc_q;
  assign ecc_q_o    = acc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       acc_q <= '0;
    else if (clear_i) acc_q <= '0;
    else if (take_i)  acc_q <= folded;
  end

endmodule

// File: rtl/ecc_syndrome_decoder.sv
module ecc_syndrome_decoder
  import ecc_pkg::*;
#(
  parameter int AW = 12,
  parameter int CW = 4,
  localparam int ECC_W = 1 + 2 * CW + 2 * AW
) (
  input  logic [ECC_W-1:0] syn_i,
  output syn_kind_e        kind_o,
  output logic [AW-1:0]    word_o,
  output logic [CW-1:0]    bit_o
);

  logic [AW-1:0] row_split;
  logic [CW-1:0] col_split;
  logic          all_split;
  logic          single_set;

  // A lone data-bit flip touches exactly one member of every pair.
  for (genvar k = 0; k < AW; k++) begin : g_row
    assign row_split[k] = syn_i[AW + k] ^ syn_i[k];
  end
  for (genvar j = 0; j < CW; j++) begin : g_col
    assign col_split[j] = syn_i[2*AW + CW + j] ^ syn_i[2*AW + j];
  end

  assign all_split  = (&row_split) & (&col_split) & syn_i[ECC_W-1];
  assign single_set = ($countones(syn_i) == 1);
  assign word_o     = syn_i[2*AW-1:AW];
  assign bit_o      = syn_i[2*AW+2*CW-1:2*AW+CW];

  always_comb begin
    if (syn_i == '0)     kind_o = SYN_CLEAN;
    else if (single_set) kind_o = SYN_CODE1;
    else if (all_split)  kind_o = SYN_DATA1;
    else                 kind_o = SYN_MULTI;
  end

endmodule

// File: rtl/nand_ecc_engine.sv
module nand_ecc_engine
  import ecc_pkg::*;
#(
  parameter int BASE_BYTES = 512,
  parameter int DW         = 16,
  localparam int AW        = $clog2(BASE_BYTES) + 3,
  localparam int CW        = $clog2(DW),
  localparam int NW        = DW / 2,
  localparam int ECC_W     = 1 + 2 * CW + 2 * AW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             bus16_i,
  input  logic [1:0]       page_sel_i,
  input  logic [DW-1:0]    data_i,
  input  logic             valid_i,
  input  logic [ECC_W-1:0] ecc_stored_i,
  output logic [ECC_W-1:0] ecc_calc_o,
  output logic             rpt_valid_o,
  output logic             err_o,
  output logic             correctable_o,
  output logic             ecc_fault_o,
  output logic             loc_valid_o,
  output logic [AW-1:0]    err_word_o,
  output logic [CW-1:0]    err_bit_o
);

  // Page configuration captured at start.
  logic       bus16_q;
  logic [1:0] sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus16_q <= 1'b0;
      sel_q   <= '0;
    end else if (start_i) begin
      bus16_q <= bus16_i;
      sel_q   <= page_sel_i;
    end
  end

  // Named internal events, also watched by the checker.
  logic [AW:0]      page_words_w;
  logic [AW-1:0]    word_cnt_w;
  logic             take_w;
  logic             last_word_w;
  logic             busy_w;
  logic [DW-1:0]    data_m;
  logic [ECC_W-1:0] ecc_q;
  logic [ECC_W-1:0] ecc_next;
  logic [ECC_W-1:0] syn_w;
  syn_kind_e        kind_w;
  logic [AW-1:0]    syn_word;
  logic [CW-1:0]    syn_bit;

  assign page_words_w = (AW+1)'(words_in_page(BASE_BYTES, sel_q, bus16_q));
  assign data_m       = bus16_q ? data_i : {{(DW-NW){1'b0}}, data_i[NW-1:0]};

  ecc_word_counter #(.AW(AW)) u_cnt (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .valid_i      (valid_i),
    .page_words_i (page_words_w),
    .addr_o       (word_cnt_w),
    .take_o       (take_w),
    .last_o       (last_word_w),
    .busy_o       (busy_w)
  );

  ecc_parity_accum #(.AW(AW), .CW(CW), .DW(DW)) u_acc (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear_i    (start_i),
    .take_i     (take_w),
    .addr_i     (word_cnt_w),
    .data_i     (data_m),
    .ecc_q_o    (ecc_q),
    .ecc_next_o (ecc_next)
  );

  assign syn_w = ecc_next ^ ecc_stored_i;

  ecc_syndrome_decoder #(.AW(AW), .CW(CW)) u_dec (
    .syn_i  (syn_w),
    .kind_o (kind_w),
    .word_o (syn_word),
    .bit_o  (syn_bit)
  );

  // Report registers: loaded at the last word, cleared by start.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rpt_valid_o   <= 1'b0;
      err_o         <= 1'b0;
      correctable_o <= 1'b0;
      ecc_fault_o   <= 1'b0;
      loc_valid_o   <= 1'b0;
      err_word_o    <= '0;
      err_bit_o     <= '0;
    end else if (start_i) begin
      rpt_valid_o   <= 1'b0;
      err_o         <= 1'b0;
      correctable_o <= 1'b0;
      ecc_fault_o   <= 1'b0;
      loc_valid_o   <= 1'b0;
      err_word_o    <= '0;
      err_bit_o     <= '0;
    end else if (last_word_w) begin
      rpt_valid_o   <= 1'b1;
      err_o         <= (kind_w != SYN_CLEAN);
      correctable_o <= (kind_w == SYN_DATA1) || (kind_w == SYN_CODE1);
      ecc_fault_o   <= (kind_w == SYN_CODE1);
      loc_valid_o   <= (kind_w == SYN_DATA1);
      err_word_o    <= (kind_w == SYN_DATA1) ? syn_word : '0;
      err_bit_o     <= (kind_w == SYN_DATA1) ? syn_bit  : '0;
    end
  end

  assign ecc_calc_o = ecc_q;

endmodule

// File: rtl/nand_ecc_checker.sv
module nand_ecc_checker #(
  parameter int AW    = 12,
  parameter int ECC_W = 33
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             last_word_w,
  input logic             busy_w,
  input logic [AW-1:0]    word_cnt_w,
  input logic [AW:0]      page_words_w,
  input logic             rpt_valid_o,
  input logic             err_o,
  input logic             correctable_o,
  input logic             ecc_fault_o,
  input logic             loc_valid_o,
  input logic [ECC_W-1:0] ecc_calc_o
);

  assert_report_after_last_R2: assert property (@(posedge clk) disable iff (!rst_n)
    last_word_w |=> rpt_valid_o);

  assert_report_not_early_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rpt_valid_o) |-> $past(last_word_w));

  assert_start_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> !rpt_valid_o);

  assert_report_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rpt_valid_o && !start_i) |=> (rpt_valid_o && $stable(ecc_calc_o) &&
      $stable({err_o, correctable_o, ecc_fault_o, loc_valid_o})));

  assert_corr_has_err_R4: assert property (@(posedge clk) disable iff (!rst_n)
    correctable_o |-> err_o);

  assert_loc_not_fault_R6: assert property (@(posedge clk) disable iff (!rst_n)
    loc_valid_o |-> (correctable_o && !ecc_fault_o));

  assert_fault_correctable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ecc_fault_o |-> correctable_o);

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rpt_valid_o |-> !(err_o || correctable_o || ecc_fault_o || loc_valid_o));

  assert_count_in_page_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_w |-> ({1'b0, word_cnt_w} < page_words_w));

endmodule

bind nand_ecc_engine nand_ecc_checker #(.AW(AW), .ECC_W(ECC_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .start_i       (start_i),
  .last_word_w   (last_word_w),
  .busy_w        (busy_w),
  .word_cnt_w    (word_cnt_w),
  .page_words_w  (page_words_w),
  .rpt_valid_o   (rpt_valid_o),
  .err_o         (err_o),
  .correctable_o (correctable_o),
  .ecc_fault_o   (ecc_fault_o),
  .loc_valid_o   (loc_valid_o),
  .ecc_calc_o    (ecc_calc_o)
);

// File: tb/nand_ecc_engine_tb.sv
module nand_ecc_engine_tb;

  localparam int AW = 12;
  localparam int EW = 33;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic          bus16_i = 1'b0;
  logic [1:0]    page_sel_i = '0;
  logic [15:0]   data_i = '0;
  logic          valid_i = 1'b0;
  logic [EW-1:0] ecc_stored_i = '0;
  logic [EW-1:0] ecc_calc_o;
  logic          rpt_valid_o, err_o, correctable_o, ecc_fault_o, loc_valid_o;
  logic [AW-1:0] err_word_o;
  logic [3:0]    err_bit_o;

  always #2.5 clk = ~clk;

  nand_ecc_engine u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .bus16_i(bus16_i),
    .page_sel_i(page_sel_i), .data_i(data_i), .valid_i(valid_i),
    .ecc_stored_i(ecc_stored_i), .ecc_calc_o(ecc_calc_o),
    .rpt_valid_o(rpt_valid_o), .err_o(err_o), .correctable_o(correctable_o),
    .ecc_fault_o(ecc_fault_o), .loc_valid_o(loc_valid_o),
    .err_word_o(err_word_o), .err_bit_o(err_bit_o)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // kind: 0 clean, 1 one data flip, 2 two data flips, 3 one stored-code flip
  typedef struct packed {
    logic        wide;
    logic [1:0]  sel;
    logic [15:0] seed;
    logic [1:0]  kind;
    logic [11:0] w0;
    logic [3:0]  b0;
    logic [11:0] w1;
    logic [3:0]  b1;
    logic [5:0]  ebit;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 2'd0, 16'h0001, 2'd0, 12'd0,    4'd0,  12'd0,   4'd0,  6'd0},
    '{1'b1, 2'd0, 16'h1234, 2'd1, 12'd5,    4'd13, 12'd0,   4'd0,  6'd0},
    '{1'b0, 2'd1, 16'hBEEF, 2'd1, 12'd1023, 4'd7,  12'd0,   4'd0,  6'd0},
    '{1'b1, 2'd2, 16'h0F0F, 2'd2, 12'd3,    4'd0,  12'd700, 4'd9,  6'd0},
    '{1'b0, 2'd0, 16'h5A5A, 2'd3, 12'd0,    4'd0,  12'd0,   4'd0,  6'd32},
    '{1'b1, 2'd1, 16'h7777, 2'd1, 12'd0,    4'd0,  12'd0,   4'd0,  6'd0},
    '{1'b0, 2'd3, 16'hC001, 2'd1, 12'd4095, 4'd0,  12'd0,   4'd0,  6'd0},
    '{1'b1, 2'd3, 16'h2468, 2'd2, 12'd10,   4'd2,  12'd10,  4'd11, 6'd0},
    '{1'b1, 2'd0, 16'h9999, 2'd3, 12'd0,    4'd0,  12'd0,   4'd0,  6'd17},
    '{1'b1, 2'd2, 16'h3C3C, 2'd0, 12'd0,    4'd0,  12'd0,   4'd0,  6'd0}
  };

  function automatic logic [15:0] gen(input logic [15:0] s, input int a);
    logic [15:0] av;
    av = 16'(a);
    return ((s ^ {av[7:0], av[15:8]}) * 16'h9E37) + (av * 16'h03B1);
  endfunction

  // Code restated per set bit: each set bit toggles one member of every pair.
  function automatic logic [EW-1:0] fold(input logic [EW-1:0] e, input int a,
                                         input logic [15:0] d, input logic wide);
    logic [EW-1:0] r;
    r = e;
    for (int b = 0; b < (wide ? 16 : 8); b++) begin
      if (d[b]) begin
        r[EW-1] = ~r[EW-1];
        for (int k = 0; k < AW; k++) begin
          if (((a >> k) & 1) != 0) r[AW + k] = ~r[AW + k];
          else                     r[k]      = ~r[k];
        end
        for (int j = 0; j < 4; j++) begin
          if (((b >> j) & 1) != 0) r[2*AW + 4 + j] = ~r[2*AW + 4 + j];
          else                     r[2*AW + j]     = ~r[2*AW + j];
        end
      end
    end
    return r;
  endfunction

  task automatic run_page(input vec_t v);
    int nwords;
    logic [EW-1:0] clean_e;
    logic [EW-1:0] sent_e;
    logic [15:0] d;
    nwords = (512 << v.sel) >> v.wide;
    clean_e = '0;
    for (int a = 0; a < nwords; a++) clean_e = fold(clean_e, a, gen(v.seed, a), v.wide);
    @(negedge clk);
    start_i = 1'b1; bus16_i = v.wide; page_sel_i = v.sel;
    ecc_stored_i = clean_e ^ ((v.kind == 2'd3) ? (EW'(1) << v.ebit) : '0);
    @(negedge clk);
    start_i = 1'b0;
    chk("R2 cleared after start", {63'd0, rpt_valid_o}, 64'd0);
    sent_e = '0;
    for (int a = 0; a < nwords; a++) begin
      if (a % 7 == 3) begin
        valid_i = 1'b0; data_i = 16'hDEAD;  // R9 gap cycle
        @(negedge clk);
      end
      d = gen(v.seed, a);
      if (v.kind == 2'd1 && a == int'(v.w0)) d[v.b0] = ~d[v.b0];
      if (v.kind == 2'd2 && a == int'(v.w0)) d[v.b0] = ~d[v.b0];
      if (v.kind == 2'd2 && a == int'(v.w1)) d[v.b1] = ~d[v.b1];
      sent_e = fold(sent_e, a, d, v.wide);
      if (!v.wide) d[15:8] = d[7:0] ^ 8'hA5;  // R8 junk upper byte
      valid_i = 1'b1; data_i = d;
      if (a == nwords - 1) begin
        #1;
        chk("R7 no report before last word", {63'd0, rpt_valid_o}, 64'd0);
      end
      @(negedge clk);
    end
    valid_i = 1'b0;
    chk("R2 report one cycle after last word", {63'd0, rpt_valid_o}, 64'd1);
    chk(v.wide ? "R1 code" : "R8 R1 code narrow", 64'(ecc_calc_o), 64'(sent_e));
    case (v.kind)
      2'd0: chk("R3 clean", {62'd0, err_o, correctable_o}, 64'd0);
      2'd1: begin
        chk("R4 flags", {60'd0, err_o, correctable_o, ecc_fault_o, loc_valid_o}, 64'b1101);
        chk("R4 location", {48'd0, err_word_o, err_bit_o}, {48'd0, v.w0, v.b0});
      end
      2'd2: chk("R5 double", {62'd0, err_o, correctable_o}, 64'b10);
      default: chk("R6 code fault", {60'd0, err_o, correctable_o, ecc_fault_o, loc_valid_o},
                   64'b1110);
    endcase
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R2 watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    logic [EW-1:0] hold_e;
    logic [3:0]    hold_f;
    repeat (3) @(negedge clk);
    chk("R10 reset report", {60'd0, rpt_valid_o, err_o, correctable_o, loc_valid_o}, 64'd0);
    chk("R10 reset code", 64'(ecc_calc_o), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) run_page(VECS[i]);

    // R9: words past the end of the page leave code and report alone.
    hold_e = ecc_calc_o;
    hold_f = {err_o, correctable_o, ecc_fault_o, loc_valid_o};
    for (int i = 0; i < 6; i++) begin
      valid_i = 1'b1; data_i = 16'h1 << i;
      @(negedge clk);
    end
    valid_i = 1'b0;
    chk("R9 code after page end", 64'(ecc_calc_o), 64'(hold_e));
    chk("R9 report after page end", {59'd0, rpt_valid_o, hold_f},
        {59'd0, 1'b1, err_o, correctable_o, ecc_fault_o, loc_valid_o});

    // R2/R10: start alone clears the report and the code.
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk("R2 start clears report", {62'd0, rpt_valid_o, err_o}, 64'd0);
    chk("R10 start clears code", 64'(ecc_calc_o), 64'd0);

    summary();
  end

endmodule